// File: doc/BRIEF.md
# Reference Clock Pre-Divider

This block sits between three reference clock inputs and a phase comparator. It is clocked by a fast system clock. It watches each reference, which arrives already sampled and resolved to a logic level. On a chosen count of rising edges it emits a one-cycle comparison event. Each lane reads its own 8-bit frequency configuration byte and its own divide ratio word, and no lane depends on the settings of another.

A lane works in one of three ways. It can pass every reference edge straight through. It can reduce a known spot frequency to 8 kHz using a ratio taken from a frequency code. It can divide by a programmable ratio N. Reference groups one and two each offer a single-ended port and a differential port, and one select bit per group picks the port that feeds the lane. Group three has a single-ended port only.

Top module: `ref_prediv`

## Requirements
- R1: While `rst` is high at a clock edge, every bit of `cmp_evt_o` is 0 after that edge. After reset every lane divider starts from a count of zero.
- R2: When configuration bits 7 and 6 are both 0, a lane pulses its `cmp_evt_o` bit for exactly one cycle for every rising edge of its selected source. The pulse appears in the cycle after the clock edge that first samples the source high.
- R3: When bit 7 is 0 and bit 6 is 1, the lane emits one pulse per R rising edges. R is taken from the code in bits 3:0: 0 gives 1 (8 kHz), 1 gives 193, 2 gives 256, 3 gives 810, 4 gives 2430, 5 gives 3240, 6 gives 4860, 7 gives 6480, 8 gives 9720 and 9 gives 19440.
- R4: In the mode of R3, codes 10 to 15 are treated as 8 kHz input, so the ratio is 1.
- R5: When bit 7 is 1, the ratio is the lane's `n_ratio_i` word, whatever the value of bit 6.
- R6: When bit 7 is 1 and the lane's N word is 0, the lane divides by 1.
- R7: A change in a lane's bits 7, 6 or 3:0, its N word, or its port select sets that lane's counter to zero. No pulse is produced in the cycle after the change.
- R8: For groups one and two, select = 1 routes the differential port to the lane and select = 0 routes the single-ended port. The port that is not selected has no effect on the events.
- R9: Each lane counts and pulses independently of the configuration and the inputs of the other lanes.
- R10: Configuration bits 5:4 have no effect on the ratio or the events, and changing them does not restart the count.
- R11: After a reset or a configuration change, the first pulse comes on the R-th rising edge. After that, pulses come on every R-th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| g1_se_i | input | 1 | Group one single-ended reference |
| g1_diff_i | input | 1 | Group one differential reference (resolved level) |
| g2_se_i | input | 1 | Group two single-ended reference |
| g2_diff_i | input | 1 | Group two differential reference (resolved level) |
| g3_se_i | input | 1 | Group three single-ended reference |
| g1_use_diff_i | input | 1 | Group one port select (1 = differential) |
| g2_use_diff_i | input | 1 | Group two port select (1 = differential) |
| freq_cfg_i | input | 3x8 | Per-lane configuration byte (bit 7 divide-by-N, bit 6 lock to 8 kHz, bits 3:0 frequency code) |
| n_ratio_i | input | 3xN_W | Per-lane divide ratio N |
| cmp_evt_o | output | 3 | Per-lane one-cycle comparison event |

## Verification
The references are driven in several patterns. In one, every selected source toggles on every cycle, so a lane in pass-through mode pulses on every other cycle. Long runs of edges check the 8 kHz ratios; the largest code runs for close to forty thousand cycles, so an off-by-one in the count moves its single event. The two ports of a group are toggled at different rates, which shows which port a lane is listening to. A reference model predicts every cycle's 3-bit event vector and a queued scoreboard compares them. Changes in the middle of a count, either to N or only to the reserved bits, show whether the counter restarts when it should and only then.

// File: rtl/ref_prediv_pkg.sv
package ref_prediv_pkg;

    localparam int NUM_LANES    = 3;
    localparam int NUM_DIFF_GRP = 2;
    localparam int CFG_W        = 8;
    localparam int CODE_W       = 4;
    localparam int RATIO_W      = 16;

    // Configuration byte layout: [7] divide-by-N, [6] lock to 8 kHz,
    // [5:4] reserved, [3:0] spot frequency code.
    typedef struct packed {
        logic              divn;
        logic              lock8k;
        logic [1:0]        rsvd;
        logic [CODE_W-1:0] code;
    } freq_cfg_t;

    typedef enum logic [1:0] {
        MODE_PASS   = 2'd0,
        MODE_LOCK8K = 2'd1,
        MODE_DIVN   = 2'd2
    } div_mode_e;

    // Divide-by-N wins over lock-to-8k.
    function automatic div_mode_e pick_mode(freq_cfg_t c);
        if (c.divn)   return MODE_DIVN;
        if (c.lock8k) return MODE_LOCK8K;
        return MODE_PASS;
    endfunction

    // Ratio that brings a spot frequency down to 8 kHz.
    function automatic logic [RATIO_W-1:0] spot_ratio(logic [CODE_W-1:0] code);
        logic [RATIO_W-1:0] r;
        case (code)
            4'd1:    r = RATIO_W'(193);
            4'd2:    r = RATIO_W'(256);
            4'd3:    r = RATIO_W'(810);
            4'd4:    r = RATIO_W'(2430);
            4'd5:    r = RATIO_W'(3240);
            4'd6:    r = RATIO_W'(4860);
            4'd7:    r = RATIO_W'(6480);
            4'd8:    r = RATIO_W'(9720);
            4'd9:    r = RATIO_W'(19440);
            default: r = RATIO_W'(1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ref_prediv_srcsel.sv
module ref_prediv_srcsel (
    input  logic se_i,
    input  logic diff_i,
    input  logic use_diff_i,
    output logic src_o
);
    always_comb begin
        src_o = use_diff_i ? diff_i : se_i;
    end
endmodule

// File: rtl/ref_prediv_lane.sv
module ref_prediv_lane
    import ref_prediv_pkg::*;
#(
    parameter int N_W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           src_i,
    input  logic           sel_i,
    input  freq_cfg_t      cfg_i,
    input  logic [N_W-1:0] n_i,
    output logic           evt_o
);
    localparam int CW = (N_W > RATIO_W) ? N_W : RATIO_W;

    typedef struct packed {
        logic              divn;
        logic              lock8k;
        logic [CODE_W-1:0] code;
        logic [N_W-1:0]    n;
        logic              sel;
    } lane_key_t;

    div_mode_e  mode;
    logic [CW-1:0] ratio;
    logic [CW-1:0] cnt_q;
    lane_key_t  key_d;
    lane_key_t  key_q;
    logic       src_q;
    logic       src_edge;
    logic       cfg_chg;
    logic       at_last;
    logic [1:0] rsvd_unused;

    assign rsvd_unused = cfg_i.rsvd;

    always_comb begin
        mode = pick_mode(cfg_i);
        case (mode)
            MODE_DIVN:   ratio = (n_i == '0) ? CW'(1) : CW'(n_i);
            MODE_LOCK8K: ratio = CW'(spot_ratio(cfg_i.code));
            default:     ratio = CW'(1);
        endcase
    end

    always_comb begin
        key_d.divn   = cfg_i.divn;
        key_d.lock8k = cfg_i.lock8k;
        key_d.code   = cfg_i.code;
        key_d.n      = n_i;
        key_d.sel    = sel_i;
    end

    assign cfg_chg  = (key_d != key_q);
    assign src_edge = src_i & ~src_q;
    assign at_last  = (cnt_q == ratio - CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= 1'b0;
            key_q <= '0;
            cnt_q <= '0;
            evt_o <= 1'b0;
        end else begin
            src_q <= src_i;
            key_q <= key_d;
            evt_o <= 1'b0;
            if (cfg_chg) begin
                cnt_q <= '0;
            end else if (src_edge) begin
                if (at_last) begin
                    cnt_q <= '0;
                    evt_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end

    // R11
    evt_wraps_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        evt_o |-> (cnt_q == '0));

    // R11
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_chg |-> (cnt_q < ratio));

    // R7
    chg_restarts_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_chg |=> ((cnt_q == '0) && !evt_o));

    // R2
    evt_has_edge_chk: assert property (@(posedge clk) disable iff (rst)
        evt_o |-> $past(src_edge && !cfg_chg));

endmodule

// File: rtl/ref_prediv.sv
module ref_prediv
    import ref_prediv_pkg::*;
#(
    parameter int N_W = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             g1_se_i,
    input  logic                             g1_diff_i,
    input  logic                             g2_se_i,
    input  logic                             g2_diff_i,
    input  logic                             g3_se_i,
    input  logic                             g1_use_diff_i,
    input  logic                             g2_use_diff_i,
    input  logic [NUM_LANES-1:0][CFG_W-1:0]  freq_cfg_i,
    input  logic [NUM_LANES-1:0][N_W-1:0]    n_ratio_i,
    output logic [NUM_LANES-1:0]             cmp_evt_o
);
    logic [NUM_LANES-1:0]    se_v;
    logic [NUM_DIFF_GRP-1:0] diff_v;
    logic [NUM_DIFF_GRP-1:0] use_diff_v;
    logic [NUM_LANES-1:0]    src_v;
    logic [NUM_LANES-1:0]    sel_v;

    assign se_v       = {g3_se_i, g2_se_i, g1_se_i};
    assign diff_v     = {g2_diff_i, g1_diff_i};
    assign use_diff_v = {g2_use_diff_i, g1_use_diff_i};

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        if (g < NUM_DIFF_GRP) begin : g_pair
            ref_prediv_srcsel u_sel (
                .se_i       (se_v[g]),
                .diff_i     (diff_v[g]),
                .use_diff_i (use_diff_v[g]),
                .src_o      (src_v[g])
            );
            assign sel_v[g] = use_diff_v[g];
        end else begin : g_single
            assign src_v[g] = se_v[g];
            assign sel_v[g] = 1'b0;
        end

        ref_prediv_lane #(.N_W(N_W)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .src_i (src_v[g]),
            .sel_i (sel_v[g]),
            .cfg_i (freq_cfg_t'(freq_cfg_i[g])),
            .n_i   (n_ratio_i[g]),
            .evt_o (cmp_evt_o[g])
        );
    end

endmodule

// File: tb/ref_prediv_tb_top.sv
`timescale 1ns/1ps
module ref_prediv_tb_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1;
    logic g1s = 1'b0, g1d = 1'b0, g2s = 1'b0, g2d = 1'b0, g3s = 1'b0;
    logic use1 = 1'b0, use2 = 1'b0;
    logic [2:0][7:0]  cfg_d = '0;
    logic [2:0][15:0] n_d   = '0;
    logic [2:0]       cmp_evt;

    ref_prediv dut_i (
        .clk(clk), .rst(rst),
        .g1_se_i(g1s), .g1_diff_i(g1d), .g2_se_i(g2s), .g2_diff_i(g2d), .g3_se_i(g3s),
        .g1_use_diff_i(use1), .g2_use_diff_i(use2),
        .freq_cfg_i(cfg_d), .n_ratio_i(n_d), .cmp_evt_o(cmp_evt)
    );

    // staged settings, applied only at a drive step
    logic       rst_s = 1'b1;
    logic [7:0] cfg_s [3];
    int         n_s   [3];
    logic       sel_s [3];

    // reference model state
    int         m_cnt [3];
    logic       m_srcp[3];
    logic [7:0] m_cfgp[3];
    int         m_np  [3];
    logic       m_selp[3];

    typedef struct { logic [2:0] exp; string tag; } item_t;
    item_t sb_q[$];

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    function automatic int b_ratio(logic [7:0] c, int n);
        if (c[7]) return (n == 0) ? 1 : n;
        if (c[6]) begin
            case (c[3:0])
                4'd1: return 193;
                4'd2: return 256;
                4'd3: return 810;
                4'd4: return 2430;
                4'd5: return 3240;
                4'd6: return 4860;
                4'd7: return 6480;
                4'd8: return 9720;
                4'd9: return 19440;
                default: return 1;
            endcase
        end
        return 1;
    endfunction

    // one drive step: apply stimulus at negedge, push expected result
    task automatic step(string tag, bit t1s, bit t1d, bit t2s, bit t2d, bit t3s);
        item_t it;
        logic  src;
        bit    chg;
        @(negedge clk);
        if (t1s) g1s = ~g1s;
        if (t1d) g1d = ~g1d;
        if (t2s) g2s = ~g2s;
        if (t2d) g2d = ~g2d;
        if (t3s) g3s = ~g3s;
        rst  = rst_s;
        use1 = sel_s[0];
        use2 = sel_s[1];
        for (int l = 0; l < 3; l++) begin
            cfg_d[l] = cfg_s[l];
            n_d[l]   = 16'(n_s[l]);
        end
        it.tag = tag;
        it.exp = 3'b000;
        for (int l = 0; l < 3; l++) begin
            case (l)
                0: src = sel_s[0] ? g1d : g1s;
                1: src = sel_s[1] ? g2d : g2s;
                default: src = g3s;
            endcase
            if (rst_s) begin
                m_cnt[l] = 0; m_srcp[l] = 1'b0; m_cfgp[l] = 8'h00;
                m_np[l] = 0; m_selp[l] = 1'b0;
                continue;
            end
            chg = ({cfg_s[l][7:6], cfg_s[l][3:0]} != {m_cfgp[l][7:6], m_cfgp[l][3:0]})
                  || (n_s[l] != m_np[l]) || (sel_s[l] != m_selp[l]);
            if (chg) begin
                m_cnt[l] = 0;
            end else if (src && !m_srcp[l]) begin
                if (m_cnt[l] == b_ratio(cfg_s[l], n_s[l]) - 1) begin
                    m_cnt[l] = 0;
                    it.exp[l] = 1'b1;
                end else begin
                    m_cnt[l] = m_cnt[l] + 1;
                end
            end
            m_srcp[l] = src; m_cfgp[l] = cfg_s[l]; m_np[l] = n_s[l]; m_selp[l] = sel_s[l];
        end
        sb_q.push_back(it);
    endtask

    // run: toggle each source every p cycles (0 = hold)
    task automatic run(string tag, int cycles, int p1s, int p1d, int p2s, int p2d, int p3s);
        for (int k = 0; k < cycles; k++) begin
            step(tag,
                 (p1s != 0) && (k % (p1s == 0 ? 1 : p1s) == 0),
                 (p1d != 0) && (k % (p1d == 0 ? 1 : p1d) == 0),
                 (p2s != 0) && (k % (p2s == 0 ? 1 : p2s) == 0),
                 (p2d != 0) && (k % (p2d == 0 ? 1 : p2d) == 0),
                 (p3s != 0) && (k % (p3s == 0 ? 1 : p3s) == 0));
        end
    endtask

    // monitor: compares one item per cycle, after the edge that produced it
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                n_cmp++;
                if (cmp_evt !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: cmp_evt actual=%b expected=%b at %0t",
                             it.tag, cmp_evt, it.exp, $time);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < 3; l++) begin
            cfg_s[l] = 8'h00; n_s[l] = 0; sel_s[l] = 1'b0;
        end
        // R1: events low while in reset, even with toggling inputs
        rst_s = 1'b1;
        run("R1", 6, 1, 1, 1, 1, 1);
        rst_s = 1'b0;
        run("R1", 4, 0, 0, 0, 0, 0);

        // R2: pass-through on all lanes
        run("R2", 40, 1, 0, 1, 0, 1);

        // R3 / R11: 8 kHz ratios 256, 193, 2430
        cfg_s[0] = 8'h42; cfg_s[1] = 8'h41; cfg_s[2] = 8'h44;
        run("R3", 10000, 1, 0, 1, 0, 1);
        // R3: 3240, 6480 and the largest ratio 19440
        cfg_s[0] = 8'h45; cfg_s[1] = 8'h47; cfg_s[2] = 8'h49;
        run("R3", 39000, 1, 0, 1, 0, 1);

        // R4 (lane1 code 12), R5 (lane0 both bits, N=5), R6 (lane2 N=0)
        cfg_s[0] = 8'hC2; n_s[0] = 5;
        cfg_s[1] = 8'h4C;
        cfg_s[2] = 8'h80; n_s[2] = 0;
        run("R5", 80, 1, 0, 1, 0, 1);

        // R9: lanes with distinct ratios 3, 7 and 4 at once
        cfg_s[0] = 8'h80; n_s[0] = 3;
        cfg_s[1] = 8'h80; n_s[1] = 7;
        cfg_s[2] = 8'h80; n_s[2] = 4;
        run("R9", 120, 1, 0, 1, 0, 1);

        // R7: change N in the middle of a count
        n_s[0] = 7;
        run("R7", 9, 1, 0, 1, 0, 1);
        n_s[0] = 3;
        run("R7", 40, 1, 0, 1, 0, 1);

        // R8: differential selected on group one, single-ended on group two
        sel_s[0] = 1'b1; sel_s[1] = 1'b0;
        run("R8", 80, 3, 1, 2, 1, 1);
        sel_s[0] = 1'b0; sel_s[1] = 1'b1;
        run("R8", 80, 1, 3, 1, 2, 1);
        sel_s[1] = 1'b0;

        // R10: reserved bits changed mid count must not restart it
        cfg_s[0] = 8'h42; n_s[0] = 0;
        run("R10", 300, 1, 0, 1, 0, 1);
        cfg_s[0] = 8'h72;
        run("R10", 400, 1, 0, 1, 0, 1);

        run("R2", 4, 0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule